// File: doc/BRIEF.md
# Double-to-Integer Converter with Saturation

This block turns a 64-bit IEEE-754 binary floating-point operand into a 32-bit or a 64-bit integer, signed or unsigned, under one of five rounding modes. It serves the conversion step of a floating-point unit. The caller presents the operand with its controls and a valid strobe. One clock edge later the block returns a 64-bit result and two exception flags: one for an invalid operation and one for an inexact result.

The operand is first aligned into a fixed frame. That alignment yields an integer magnitude, a guard bit and a sticky bit. The magnitude is rounded as an unsigned number and only then negated when the operand is negative. Overflow is read from a pair of bits sitting just above the target field. Values that do not fit, infinities and NaNs are replaced by fixed limits that depend on direction and type. A 32-bit result always comes back sign-extended from its bit 31.

Top module: `f2i_conv`

## Requirements
- R1: When `in_valid` is high at a rising edge, `result` and both flags are loaded and `out_valid` is high after that edge. When `in_valid` is low, `result` and the flags keep their values and `out_valid` is low. Reset clears all outputs.
- R2: A finite in-range operand gives its value rounded to an integer. The `rmode` codes are 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity and 100 nearest with ties away from zero. Codes 101 to 111 act as 000.
- R3: With `is_wide`=0 the result is 32 bits wide, and bits 63:32 repeat bit 31. This holds for unsigned results as well, so 2^31 converted unsigned gives 0xFFFFFFFF80000000.
- R4: Negative infinity, or a negative value whose rounded magnitude is out of range, saturates as follows. Signed 32-bit gives 0xFFFFFFFF80000000. Signed 64-bit gives 0x8000000000000000. Unsigned of either width gives 0.
- R5: Positive infinity, a positive value above range, or any NaN whatever its sign bit, saturates as follows. Signed 32-bit gives 0x000000007FFFFFFF. Signed 64-bit gives 0x7FFFFFFFFFFFFFFF. Unsigned 32-bit and unsigned 64-bit both give all ones.
- R6: Whenever the result saturates, or the operand is infinity or NaN, `flag_invalid` is 1 and `flag_inexact` is 0.
- R7: When no saturation occurs, `flag_inexact` is 1 exactly when the operand had a nonzero fractional part.
- R8: A negative operand that rounds to zero for an unsigned result returns 0 with only `flag_inexact` set.
- R9: Both zeros give 0 with no flags. A subnormal gives 0 with `flag_inexact` set, unless a directed mode rounds it away from zero. In that case it gives +1, or -1 for a signed result, or saturates as in R4 and R6 when the operand is negative and the result is unsigned.
- R10: The exact signed limits are honoured. -2^63 converts signed 64-bit to 0x8000000000000000 with no flags. +2^63 saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| op_bits | input | 64 | Binary64 operand |
| is_signed | input | 1 | 1: signed result, 0: unsigned |
| is_wide | input | 1 | 1: 64-bit result, 0: 32-bit result |
| rmode | input | 3 | Rounding mode code (R2) |
| out_valid | output | 1 | Result and flags were loaded at the last edge |
| result | output | 64 | Converted integer, 32-bit results sign-extended |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Inexact flag |

## Verification
Every result, flag and `out_valid` is due on the first rising edge after the edge-setup where `in_valid` is raised. The bench changes inputs on falling edges and reads the outputs on the next falling edge, so exactly one register stage lies between stimulus and sample. For the hold behaviour, the bench drops `in_valid`, changes the operand, and checks one falling edge later that the outputs have not moved and `out_valid` is low. Expected values come from an arithmetic model that splits the operand into integer part and remainder, rather than the fixed-frame shift used in the design.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int OP_W    = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int BIAS    = 1023;
    localparam int INT_W   = 64;
    localparam int NARROW_W = 32;
    localparam int FRAME_W = 2 * INT_W;
    localparam int SUM_W   = INT_W + 2;
    localparam int SH_W    = 7;
    // biased exponent whose unit bit lands at frame bit INT_W (value 1.x)
    localparam int EXP_ONE = BIAS;
    // smallest biased exponent whose leading one falls outside the integer field
    localparam int EXP_HUGE = BIAS + INT_W;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'b000,
        RM_ZERO      = 3'b001,
        RM_DOWN      = 3'b010,
        RM_UP        = 3'b011,
        RM_NEAR_MAX  = 3'b100
    } rmode_e;

    typedef struct packed {
        logic             neg;
        logic             nan;
        logic             inf;
        logic             huge;
        logic [INT_W-1:0] ipart;
        logic             guard;
        logic             sticky;
    } aligned_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } conv_out_t;

    // decide whether the truncated magnitude is bumped by one
    function automatic logic round_bump(input logic [2:0] rm, input logic neg,
                                        input logic lsb, input logic g, input logic s);
        logic bump;
        case (rm)
            RM_ZERO:     bump = 1'b0;
            RM_DOWN:     bump = neg & (g | s);
            RM_UP:       bump = ~neg & (g | s);
            RM_NEAR_MAX: bump = g;
            default:     bump = g & (s | lsb);
        endcase
        return bump;
    endfunction

    // clamp value for out-of-range inputs, fixed per direction and type
    function automatic logic [INT_W-1:0] clamp_value(input logic to_neg, input logic sgn,
                                                     input logic wide);
        logic [INT_W-1:0] v;
        if (to_neg) begin
            if (!sgn)      v = '0;
            else if (wide) v = {1'b1, {(INT_W-1){1'b0}}};
            else           v = {{(INT_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};
        end else begin
            if (!sgn)      v = '1;
            else if (wide) v = {1'b0, {(INT_W-1){1'b1}}};
            else           v = {{(INT_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
        end
        return v;
    endfunction

endpackage

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output aligned_t        al
);

    logic [EXP_W-1:0]   bexp;
    logic [FRAC_W-1:0]  frac;
    logic               exp_max;
    logic               normal;
    logic [MANT_W-1:0]  mant;
    logic [SH_W-1:0]    shamt;
    logic [FRAME_W-1:0] frame;

    assign bexp    = op[OP_W-2 -: EXP_W];
    assign frac    = op[FRAC_W-1:0];
    assign exp_max = &bexp;
    assign normal  = |bexp;
    assign mant    = {normal, frac};

    // leading one sits at frame bit FRAME_W-1; its weight must be at bit INT_W+e
    always_comb begin
        if (!normal || bexp < EXP_W'(EXP_ONE - 1))
            shamt = SH_W'(INT_W + 1);
        else if (bexp >= EXP_W'(EXP_HUGE))
            shamt = '0;
        else
            shamt = SH_W'(EXP_W'(EXP_HUGE - 1) - bexp);
    end

    assign frame = {mant, {(FRAME_W-MANT_W){1'b0}}} >> shamt;

    always_comb begin
        al.neg    = op[OP_W-1];
        al.nan    = exp_max & (|frac);
        al.inf    = exp_max & ~(|frac);
        al.huge   = ~exp_max & (bexp >= EXP_W'(EXP_HUGE));
        al.ipart  = frame[FRAME_W-1 -: INT_W];
        al.guard  = frame[INT_W-1];
        al.sticky = |frame[INT_W-2:0];
    end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  aligned_t  al,
    input  logic      sgn,
    input  logic      wide,
    input  logic [2:0] rm,
    output conv_out_t co
);

    logic             bump;
    logic [SUM_W-1:0] mag;
    logic [SUM_W-1:0] twos;
    logic [1:0]       top2;
    logic             top_bad;
    logic             narrow_big;
    logic             ovf;
    logic             special;

    assign bump = round_bump(rm, al.neg, al.ipart[0], al.guard, al.sticky);

    // round the magnitude, then negate for a negative operand
    assign mag  = {2'b00, al.ipart} + {{(SUM_W-1){1'b0}}, bump};
    assign twos = al.neg ? (~mag + {{(SUM_W-1){1'b0}}, 1'b1}) : mag;

    always_comb begin
        case ({sgn, wide})
            2'b11:   top2 = twos[INT_W:INT_W-1];
            2'b10:   top2 = twos[NARROW_W:NARROW_W-1];
            2'b01:   top2 = twos[INT_W+1:INT_W];
            default: top2 = twos[NARROW_W+1:NARROW_W];
        endcase
    end

    // signed: the two bits must agree; unsigned: both must be zero
    assign top_bad    = sgn ? (top2[1] ^ top2[0]) : (|top2);
    assign narrow_big = ~wide & (|mag[SUM_W-1:NARROW_W]);
    assign ovf        = al.huge | narrow_big | top_bad;
    assign special    = al.nan | al.inf;

    always_comb begin
        co.invalid = special | ovf;
        co.inexact = ~co.invalid & (al.guard | al.sticky);
        if (co.invalid)
            co.value = clamp_value(al.neg & ~al.nan, sgn, wide);
        else if (wide)
            co.value = twos[INT_W-1:0];
        else
            co.value = {{(INT_W-NARROW_W){twos[NARROW_W-1]}}, twos[NARROW_W-1:0]};
    end

endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_bits,
    input  logic             is_signed,
    input  logic             is_wide,
    input  logic [2:0]       rmode,
    output logic             out_valid,
    output logic [INT_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_inexact
);

    aligned_t  al;
    conv_out_t co;

    f2i_align u_align (
        .op (op_bits),
        .al (al)
    );

    f2i_round u_round (
        .al   (al),
        .sgn  (is_signed),
        .wide (is_wide),
        .rm   (rmode),
        .co   (co)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= co.value;
                flag_invalid <= co.invalid;
                flag_inexact <= co.inexact;
            end
        end
    end

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(flag_invalid) && $stable(flag_inexact))); // R1
    AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_wide) |=> (result[INT_W-1:NARROW_W] == {(INT_W-NARROW_W){result[NARROW_W-1]}})); // R3
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(flag_invalid && flag_inexact)); // R6
    AST_NAN_INVALID: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (&op_bits[OP_W-2 -: EXP_W]) && (|op_bits[FRAC_W-1:0])) |=> (flag_invalid && !flag_inexact)); // R6
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_bits[OP_W-2:0] == '0) |=> (result == '0 && !flag_invalid && !flag_inexact)); // R9

endmodule

// File: tb/f2i_conv_tb.sv
`timescale 1ns/1ps
module f2i_conv_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] op_bits;
    logic        is_signed;
    logic        is_wide;
    logic [2:0]  rmode;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_invalid;
    logic        flag_inexact;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    f2i_conv u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_bits(op_bits),
        .is_signed(is_signed), .is_wide(is_wide), .rmode(rmode),
        .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    function automatic logic [63:0] limit_of(input logic neg, input logic sg, input logic wd);
        if (neg) return sg ? (wd ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000) : 64'd0;
        if (sg)  return wd ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
        return 64'hFFFF_FFFF_FFFF_FFFF;
    endfunction

    // returns {invalid, inexact, value}
    function automatic logic [65:0] model(input logic [63:0] x, input logic sg,
                                          input logic wd, input logic [2:0] rm);
        logic s, gt, eq, nz, up, big;
        int e, k;
        logic [127:0] m, ip, remd, half, mag, lim, neg128;
        logic [63:0] r;
        s = x[63];
        if (x[62:52] == 11'h7FF)
            return {1'b1, 1'b0, limit_of(s && x[51:0] == 0, sg, wd)};
        m = {76'd0, x[51:0]};
        if (x[62:52] != 0) m[52] = 1'b1;
        e = (x[62:52] == 0) ? -1074 : int'({21'd0, x[62:52]}) - 1075;
        big = 0; gt = 0; eq = 0; nz = 0; ip = '0;
        if (e >= 0) begin
            if (e > 70) big = 1; else ip = m << e;
        end else if (-e >= 120) begin
            nz = (m != 0);
        end else begin
            k = -e;
            ip = m >> k;
            remd = m - (ip << k);
            half = 128'd1 << (k - 1);
            gt = remd > half; eq = remd == half; nz = remd != 0;
        end
        case (rm)
            3'd1: up = 0;
            3'd2: up = s & nz;
            3'd3: up = ~s & nz;
            3'd4: up = gt | eq;
            default: up = gt | (eq & ip[0]);
        endcase
        mag = ip + {127'd0, up};
        if (s) lim = sg ? (128'd1 << (wd ? 63 : 31)) : 128'd0;
        else   lim = sg ? (128'd1 << (wd ? 63 : 31)) - 1 : (128'd1 << (wd ? 64 : 32)) - 1;
        if (big || mag > lim) return {1'b1, 1'b0, limit_of(s, sg, wd)};
        neg128 = -mag;
        r = s ? neg128[63:0] : mag[63:0];
        if (!wd) r = {{32{r[31]}}, r[31:0]};
        return {1'b0, nz, r};
    endfunction

    task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got inv=%0b inx=%0b val=%h expected inv=%0b inx=%0b val=%h",
                     tag, got[65], got[64], got[63:0], exp[65], exp[64], exp[63:0]);
        end
    endtask

    task automatic run_one(input string tag, input logic [63:0] x, input logic sg,
                           input logic wd, input logic [2:0] rm);
        logic [65:0] exp;
        exp = model(x, sg, wd, rm);
        @(negedge clk);
        in_valid = 1'b1; op_bits = x; is_signed = sg; is_wide = wd; rmode = rm;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 valid", {65'd0, out_valid}, 66'd1);
        check(tag, {flag_invalid, flag_inexact, result}, exp);
    endtask

    function automatic string auto_tag(input logic [65:0] exp, input logic wd);
        if (exp[65]) return exp[63] && exp[62] ? "R4" : "R5";
        if (!wd) return "R3";
        if (exp[64]) return "R7";
        return "R2";
    endfunction

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic [65:0] held;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; op_bits = '0; is_signed = 0; is_wide = 0; rmode = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", {flag_invalid, flag_inexact, result}, 66'd0);
        check("R1 reset valid", {65'd0, out_valid}, 66'd0);

        run_one("R2 rne 2.5",      64'h4004_0000_0000_0000, 1, 1, 3'd0);
        run_one("R2 rne 3.5",      64'h400C_0000_0000_0000, 1, 1, 3'd0);
        run_one("R2 rmm -2.5",     64'hC004_0000_0000_0000, 1, 1, 3'd4);
        run_one("R2 rdn 2.5",      64'h4004_0000_0000_0000, 1, 1, 3'd2);
        run_one("R2 rdn -2.5",     64'hC004_0000_0000_0000, 1, 1, 3'd2);
        run_one("R2 rup 2.5",      64'h4004_0000_0000_0000, 1, 1, 3'd3);
        run_one("R2 code7 2.5",    64'h4004_0000_0000_0000, 1, 1, 3'd7);
        run_one("R2 exact 4",      64'h4010_0000_0000_0000, 0, 1, 3'd0);
        run_one("R3 -1 s32",       64'hBFF0_0000_0000_0000, 1, 0, 3'd0);
        run_one("R3 2^31 u32",     64'h41E0_0000_0000_0000, 0, 0, 3'd0);
        run_one("R5 +inf s32",     64'h7FF0_0000_0000_0000, 1, 0, 3'd0);
        run_one("R4 -inf s64",     64'hFFF0_0000_0000_0000, 1, 1, 3'd0);
        run_one("R4 -inf s32",     64'hFFF0_0000_0000_0000, 1, 0, 3'd0);
        run_one("R5 nan u64",      64'h7FF8_0000_0000_0000, 0, 1, 3'd0);
        run_one("R5 -nan s32",     64'hFFF8_0000_0000_0001, 1, 0, 3'd1);
        run_one("R5 2^64 u64",     64'h43F0_0000_0000_0000, 0, 1, 3'd0);
        run_one("R5 2^32 u32",     64'h41F0_0000_0000_0000, 0, 0, 3'd0);
        run_one("R10 2^63 s64",    64'h43E0_0000_0000_0000, 1, 1, 3'd0);
        run_one("R10 -2^63 s64",   64'hC3E0_0000_0000_0000, 1, 1, 3'd0);
        run_one("R10 -2^31 s32",   64'hC1E0_0000_0000_0000, 1, 0, 3'd0);
        run_one("R10 2^31 s32",    64'h41E0_0000_0000_0000, 1, 0, 3'd0);
        run_one("R8 -0.3 u rtz",   64'hBFD3_3333_3333_3333, 0, 1, 3'd1);
        run_one("R8 -0.3 u32 rne", 64'hBFD3_3333_3333_3333, 0, 0, 3'd0);
        run_one("R4 -1 u64",       64'hBFF0_0000_0000_0000, 0, 1, 3'd0);
        run_one("R9 +0",           64'h0000_0000_0000_0000, 1, 1, 3'd0);
        run_one("R9 -0 u",         64'h8000_0000_0000_0000, 0, 1, 3'd2);
        run_one("R9 sub rne",      64'h0000_0000_0000_0001, 1, 1, 3'd0);
        run_one("R9 sub rup",      64'h0000_0000_0000_0001, 1, 0, 3'd3);
        run_one("R9 -sub rdn s",   64'h8000_0000_0000_0001, 1, 1, 3'd2);
        run_one("R9 -sub rdn u",   64'h8000_0000_0000_0001, 0, 1, 3'd2);
        run_one("R7 1.5 rtz",      64'h3FF8_0000_0000_0000, 1, 1, 3'd1);
        run_one("R7 0.5 rne",      64'h3FE0_0000_0000_0000, 1, 1, 3'd0);

        // R1: idle cycle must not disturb outputs
        run_one("R7 1.5 rne", 64'h3FF8_0000_0000_0000, 1, 1, 3'd0);
        held = {flag_invalid, flag_inexact, result};
        @(negedge clk);
        op_bits = 64'h7FF0_0000_0000_0000; rmode = 3'd3;
        @(negedge clk);
        check("R1 hold", {flag_invalid, flag_inexact, result}, held);
        check("R1 idle valid", {65'd0, out_valid}, 66'd0);

        for (int i = 0; i < 4000; i++) begin
            logic [63:0] x;
            logic [10:0] ex;
            logic [65:0] exp;
            logic sg, wd;
            logic [2:0] rm;
            x = {$urandom, $urandom};
            case ($urandom % 4)
                0: ex = x[62:52];
                1: ex = 11'(1020 + ($urandom % 70));
                2: ex = 11'(990 + ($urandom % 36));
                default: begin
                    case ($urandom % 6)
                        0: ex = 11'd0;
                        1: ex = 11'h7FF;
                        2: ex = 11'd1086;
                        3: ex = 11'd1087;
                        4: ex = 11'd1054;
                        default: ex = 11'd1055;
                    endcase
                end
            endcase
            x[62:52] = ex;
            if (($urandom % 8) == 0) x[51:0] = '0;
            sg = 1'($urandom); wd = 1'($urandom); rm = 3'($urandom);
            exp = model(x, sg, wd, rm);
            run_one(auto_tag(exp, wd), x, sg, wd, rm);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule